// File: doc/BRIEF.md
# Eight-Pin GPIO Port Controller with Pad Resolution and Pin Interrupts

This block manages one general-purpose I/O port. Software reaches it through a flat register bus: a write strobe, a 4-bit register address and a data word carrying one bit per pin, with read data returned combinationally for the current address. For each pin the block stores direction, digital enable, open-drain, pull-up, pull-down, slew and alternate-function select. From these it resolves the pad's output enable, output value and pull controls. When a pin is handed to a peripheral, the peripheral's own enable and data take over.

Pin inputs pass through a two-stage synchronizer and are gated by digital enable. The gated levels feed two consumers: the attached peripherals, and a per-pin interrupt detector. Each pin can be sensed on an edge or on a level. The event bit selects rising/high or falling/low, and a both-edges bit overrides it. Raw status is kept per pin. Edge-sensed bits are sticky and are cleared by writing ones. The masked status drives a single interrupt line. Designated protected pins can be locked, after which their configuration bits refuse writes until reset.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every pin is undriven: pad_oe, pad_pu, pad_pd and irq are 0, and every configuration register reads 0.
- R2: A pin whose digital-enable bit (address 2) is 0 never has pad_oe asserted, and its synchronized input reads 0 at the input register (address 15) and at periph_in.
- R3: With alternate select (address 7) at 0, direction (address 1) chooses the mode. A 0 leaves the pin an input. A 1 drives the pad with the pin's data bit (address 0).
- R4: With open-drain (address 3) set on a driven pin, a data value of 0 asserts pad_oe with pad_out 0, and a data value of 1 releases pad_oe. pad_out is 0 whenever pad_oe is 0.
- R5: With alternate select at 1, periph_oe and periph_out replace direction and data, and the direction bit has no effect. Open-drain still applies to the peripheral's data.
- R6: The pull-up (address 4) and pull-down (address 5) bits appear unchanged on pad_pu and pad_pd. The slew bits (address 6) appear on pad_slew and read back.
- R7: A pin with sense bit (address 8) at 0 is edge sensed. With both-edges (address 9) at 1, either edge sets its raw bit. Otherwise event (address 10) at 1 selects rising and 0 selects falling.
- R8: Edge-sensed raw bits (read at address 12) stay set until a 1 is written to that bit position at address 12. Writing 0 leaves them set.
- R9: A level-sensed pin's raw bit follows the gated level: high when event is 1, low when event is 0. A clear write has no effect on it.
- R10: The masked status (address 13) is raw AND mask (address 11), and irq is 1 exactly when any masked bit is 1.
- R11: Writing ones to the lock register (address 14) sets lock bits for the protected pins only (parameter PROT_PINS, default 8'h03). Lock bits cannot be cleared by writes. A locked pin's direction, enable, open-drain, pull, slew and alternate bits ignore writes. Its data bit still accepts them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | NUM_PINS | Write data, one bit per pin |
| bus_rdata | output | NUM_PINS | Read data for bus_addr |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_oe | output | NUM_PINS | Pad driver enable |
| pad_out | output | NUM_PINS | Pad driver value |
| pad_pu | output | NUM_PINS | Pad pull-up enable |
| pad_pd | output | NUM_PINS | Pad pull-down enable |
| pad_slew | output | NUM_PINS | Pad slew control |
| periph_oe | input | NUM_PINS | Peripheral output enable per pin |
| periph_out | input | NUM_PINS | Peripheral output data per pin |
| periph_in | output | NUM_PINS | Synchronized, enable-gated input to peripherals |
| irq | output | 1 | Combined masked interrupt |

## Verification
On every cycle, the assertions check the pad-side invariants. A disabled pin is never driven. An open-drain pin never drives high. An alternate pin follows the peripheral's enable. A zero mask keeps irq low. Lock bits never fall, locked direction bits do not move on a write, and edge-sensed raw bits do not drop without a clear. The bench scenarios show the remaining behaviour. They cover the exact resolved pad values for mixed direction, open-drain and alternate settings, and edge detection with each polarity and with both-edges priority. They also cover level tracking that ignores clears, the effect of the mask on irq, and the lock refusing writes while the data register still accepts them.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [3:0] {
        REG_DOUT  = 4'd0,
        REG_DIR   = 4'd1,
        REG_DEN   = 4'd2,
        REG_ODE   = 4'd3,
        REG_PU    = 4'd4,
        REG_PD    = 4'd5,
        REG_SLEW  = 4'd6,
        REG_ALT   = 4'd7,
        REG_SENSE = 4'd8,
        REG_BOTH  = 4'd9,
        REG_EVT   = 4'd10,
        REG_MASK  = 4'd11,
        REG_RAW   = 4'd12,
        REG_MIS   = 4'd13,
        REG_LOCK  = 4'd14,
        REG_IN    = 4'd15
    } gpio_reg_e;

    localparam int unsigned ADDR_W = 4;

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned N         = 8,
    parameter logic [N-1:0] PROT_PINS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      dout,
    output logic [N-1:0]      dir,
    output logic [N-1:0]      den,
    output logic [N-1:0]      ode,
    output logic [N-1:0]      pu,
    output logic [N-1:0]      pd,
    output logic [N-1:0]      slew,
    output logic [N-1:0]      alt,
    output logic [N-1:0]      sense,
    output logic [N-1:0]      both,
    output logic [N-1:0]      evt,
    output logic [N-1:0]      mask,
    output logic [N-1:0]      lock,
    output logic [N-1:0]      raw_clr
);

    typedef struct packed {
        logic [N-1:0] dout;
        logic [N-1:0] dir;
        logic [N-1:0] den;
        logic [N-1:0] ode;
        logic [N-1:0] pu;
        logic [N-1:0] pd;
        logic [N-1:0] slew;
        logic [N-1:0] alt;
        logic [N-1:0] sense;
        logic [N-1:0] both;
        logic [N-1:0] evt;
        logic [N-1:0] mask;
        logic [N-1:0] lock;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [N-1:0] keep;

    // merge new data into a protected field, keeping locked positions
    function automatic logic [N-1:0] guarded(input logic [N-1:0] old_v,
                                             input logic [N-1:0] new_v,
                                             input logic [N-1:0] hold);
        return (old_v & hold) | (new_v & ~hold);
    endfunction

    assign keep = cfg_q.lock;

    always_comb begin
        cfg_d   = cfg_q;
        raw_clr = '0;
        if (we) begin
            unique case (gpio_reg_e'(addr))
                REG_DOUT:  cfg_d.dout  = wdata;
                REG_DIR:   cfg_d.dir   = guarded(cfg_q.dir,  wdata, keep);
                REG_DEN:   cfg_d.den   = guarded(cfg_q.den,  wdata, keep);
                REG_ODE:   cfg_d.ode   = guarded(cfg_q.ode,  wdata, keep);
                REG_PU:    cfg_d.pu    = guarded(cfg_q.pu,   wdata, keep);
                REG_PD:    cfg_d.pd    = guarded(cfg_q.pd,   wdata, keep);
                REG_SLEW:  cfg_d.slew  = guarded(cfg_q.slew, wdata, keep);
                REG_ALT:   cfg_d.alt   = guarded(cfg_q.alt,  wdata, keep);
                REG_SENSE: cfg_d.sense = wdata;
                REG_BOTH:  cfg_d.both  = wdata;
                REG_EVT:   cfg_d.evt   = wdata;
                REG_MASK:  cfg_d.mask  = wdata;
                REG_RAW:   raw_clr     = wdata;
                REG_LOCK:  cfg_d.lock  = cfg_q.lock | (wdata & PROT_PINS);
                default:   cfg_d       = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign dout  = cfg_q.dout;
    assign dir   = cfg_q.dir;
    assign den   = cfg_q.den;
    assign ode   = cfg_q.ode;
    assign pu    = cfg_q.pu;
    assign pd    = cfg_q.pd;
    assign slew  = cfg_q.slew;
    assign alt   = cfg_q.alt;
    assign sense = cfg_q.sense;
    assign both  = cfg_q.both;
    assign evt   = cfg_q.evt;
    assign mask  = cfg_q.mask;
    assign lock  = cfg_q.lock;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned N      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);

    logic [STAGES-1:0][N-1:0] st_d, st_q;

    assign st_d[0] = async_in;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        assign st_d[s] = st_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] dout,
    input  logic [N-1:0] dir,
    input  logic [N-1:0] den,
    input  logic [N-1:0] ode,
    input  logic [N-1:0] alt,
    input  logic [N-1:0] periph_oe,
    input  logic [N-1:0] periph_out,
    output logic [N-1:0] pad_oe,
    output logic [N-1:0] pad_out
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic want_drive;
        logic want_val;
        logic oe_q;

        // source select: peripheral or software
        assign want_drive = alt[i] ? periph_oe[i]  : dir[i];
        assign want_val   = alt[i] ? periph_out[i] : dout[i];

        // open drain only ever pulls low
        assign oe_q       = den[i] & want_drive & (~ode[i] | ~want_val);
        assign pad_oe[i]  = oe_q;
        assign pad_out[i] = oe_q & want_val & ~ode[i];
    end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] sense,
    input  logic [N-1:0] both,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] clr,
    output logic [N-1:0] raw,
    output logic [N-1:0] masked,
    output logic         irq
);

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] raw;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic [N-1:0] raw_nxt;

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic rise, fall, edge_hit, lvl_hit;

        assign rise     = lvl[i] & ~st_q.prev[i];
        assign fall     = ~lvl[i] & st_q.prev[i];
        assign edge_hit = both[i] ? (rise | fall) : (evt[i] ? rise : fall);
        assign lvl_hit  = evt[i] ? lvl[i] : ~lvl[i];
        // a new edge wins over a clear in the same cycle
        assign raw_nxt[i] = sense[i] ? lvl_hit
                                     : ((st_q.raw[i] & ~clr[i]) | edge_hit);
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        st_d.raw  = raw_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw    = st_q.raw;
    assign masked = st_q.raw & mask;
    assign irq    = |masked;

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int unsigned  NUM_PINS  = 8,
    parameter int unsigned  SYNC_STG  = 2,
    parameter logic [NUM_PINS-1:0] PROT_PINS = 8'h03
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_pu,
    output logic [NUM_PINS-1:0] pad_pd,
    output logic [NUM_PINS-1:0] pad_slew,
    input  logic [NUM_PINS-1:0] periph_oe,
    input  logic [NUM_PINS-1:0] periph_out,
    output logic [NUM_PINS-1:0] periph_in,
    output logic                irq
);

    localparam int unsigned N = NUM_PINS;

    logic [N-1:0] c_dout, c_dir, c_den, c_ode, c_pu, c_pd, c_slew, c_alt;
    logic [N-1:0] c_sense, c_both, c_evt, c_mask, c_lock, c_clr;
    logic [N-1:0] in_sync, in_lvl, st_raw, st_mis;

    gpio_cfg_regs #(.N(N), .PROT_PINS(PROT_PINS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .dout(c_dout), .dir(c_dir), .den(c_den), .ode(c_ode), .pu(c_pu),
        .pd(c_pd), .slew(c_slew), .alt(c_alt), .sense(c_sense), .both(c_both),
        .evt(c_evt), .mask(c_mask), .lock(c_lock), .raw_clr(c_clr)
    );

    gpio_in_sync #(.N(N), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(in_sync)
    );

    assign in_lvl    = in_sync & c_den;
    assign periph_in = in_lvl;

    gpio_pad_mux #(.N(N)) u_pad (
        .dout(c_dout), .dir(c_dir), .den(c_den), .ode(c_ode), .alt(c_alt),
        .periph_oe(periph_oe), .periph_out(periph_out),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    gpio_irq_unit #(.N(N)) u_irq (
        .clk(clk), .rst_n(rst_n), .lvl(in_lvl), .sense(c_sense), .both(c_both),
        .evt(c_evt), .mask(c_mask), .clr(c_clr),
        .raw(st_raw), .masked(st_mis), .irq(irq)
    );

    assign pad_pu   = c_pu;
    assign pad_pd   = c_pd;
    assign pad_slew = c_slew;

    always_comb begin
        unique case (gpio_reg_e'(bus_addr))
            REG_DOUT:  bus_rdata = c_dout;
            REG_DIR:   bus_rdata = c_dir;
            REG_DEN:   bus_rdata = c_den;
            REG_ODE:   bus_rdata = c_ode;
            REG_PU:    bus_rdata = c_pu;
            REG_PD:    bus_rdata = c_pd;
            REG_SLEW:  bus_rdata = c_slew;
            REG_ALT:   bus_rdata = c_alt;
            REG_SENSE: bus_rdata = c_sense;
            REG_BOTH:  bus_rdata = c_both;
            REG_EVT:   bus_rdata = c_evt;
            REG_MASK:  bus_rdata = c_mask;
            REG_RAW:   bus_rdata = st_raw;
            REG_MIS:   bus_rdata = st_mis;
            REG_LOCK:  bus_rdata = c_lock;
            REG_IN:    bus_rdata = in_lvl;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
    import gpio_port_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N-1:0]      pad_oe,
    input logic [N-1:0]      pad_out,
    input logic [N-1:0]      pad_pu,
    input logic [N-1:0]      pad_pd,
    input logic [N-1:0]      periph_oe,
    input logic [N-1:0]      periph_in,
    input logic              irq,
    input logic [N-1:0]      den,
    input logic [N-1:0]      ode,
    input logic [N-1:0]      alt,
    input logic [N-1:0]      dir,
    input logic [N-1:0]      mask,
    input logic [N-1:0]      lock,
    input logic [N-1:0]      sense,
    input logic [N-1:0]      raw
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0 && !irq));

    // R2
    den_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | periph_in) & ~den) == '0);

    // R4
    od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_out & ode) == '0);

    // R5
    alt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((alt & den & ~ode) & (pad_oe ^ periph_oe)) == '0);

    // R8
    edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && (bus_addr == REG_RAW || bus_addr == REG_SENSE))
        |=> (($past(raw) & ~$past(sense)) & ~raw) == '0);

    // R10
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    // R11
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock) & ~lock) == '0);

    // R11
    lock_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_DIR) |=> ((dir ^ $past(dir)) & $past(lock)) == '0);

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.N(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .periph_oe(periph_oe), .periph_in(periph_in), .irq(irq),
    .den(c_den), .ode(c_ode), .alt(c_alt), .dir(c_dir), .mask(c_mask),
    .lock(c_lock), .sense(c_sense), .raw(st_raw)
);

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
    import gpio_port_pkg::*;

    localparam int N = 8;
    localparam int OBS_OE = 0, OBS_OUT = 1, OBS_PU = 2, OBS_PD = 3,
                   OBS_IRQ = 4, OBS_RD = 5, OBS_SLEW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_oe, pad_out, pad_pu, pad_pd, pad_slew, periph_in;
    logic [N-1:0]  periph_oe = '0;
    logic [N-1:0]  periph_out = '0;
    logic          irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        string        req;
        int           sel;
        logic [N-1:0] exp;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #4 clk = ~clk;

    gpio_port_ctrl u_gpio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_slew(pad_slew), .periph_oe(periph_oe), .periph_out(periph_out),
        .periph_in(periph_in), .irq(irq)
    );

    function automatic logic [N-1:0] observe(int sel);
        case (sel)
            OBS_OE:   return pad_oe;
            OBS_OUT:  return pad_out;
            OBS_PU:   return pad_pu;
            OBS_PD:   return pad_pd;
            OBS_IRQ:  return {{(N-1){1'b0}}, irq};
            OBS_SLEW: return pad_slew;
            default:  return bus_rdata;
        endcase
    endfunction

    // monitor: compares queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                logic [N-1:0] act;
                it  = sb_q.pop_front();
                act = observe(it.sel);
                tests++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic wr(gpio_reg_e a, logic [N-1:0] d);
        step(1);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic expect_obs(string req, int sel, logic [N-1:0] e);
        exp_item_t it;
        it.req = req; it.sel = sel; it.exp = e;
        sb_q.push_back(it);
    endtask

    task automatic expect_rd(string req, gpio_reg_e a, logic [N-1:0] e);
        step(1);
        bus_addr = a;
        expect_obs(req, OBS_RD, e);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        expect_obs("R1 oe", OBS_OE, 8'h00);
        expect_obs("R1 pu", OBS_PU, 8'h00);
        expect_obs("R1 pd", OBS_PD, 8'h00);
        expect_obs("R1 irq", OBS_IRQ, 8'h00);
        expect_rd("R1 den", REG_DEN, 8'h00);
        expect_rd("R1 alt", REG_ALT, 8'h00);

        // R3 plain outputs
        wr(REG_DEN, 8'hFF);
        wr(REG_DIR, 8'h0F);
        wr(REG_DOUT, 8'hA5);
        step(1);
        expect_obs("R3 oe", OBS_OE, 8'h0F);
        expect_obs("R3 out", OBS_OUT, 8'h05);

        // R2 enable gating
        wr(REG_DEN, 8'h0E);
        pad_in = 8'hFF;
        step(4);
        expect_obs("R2 oe", OBS_OE, 8'h0E);
        expect_rd("R2 in", REG_IN, 8'h0E);

        // R4 open drain
        wr(REG_DEN, 8'hFF);
        wr(REG_ODE, 8'h03);
        step(1);
        expect_obs("R4 oe", OBS_OE, 8'h0E);
        expect_obs("R4 out", OBS_OUT, 8'h04);

        // R5 alternate function overrides direction
        wr(REG_ALT, 8'h31);
        periph_oe  = 8'h30;
        periph_out = 8'h30;
        step(1);
        expect_obs("R5 oe", OBS_OE, 8'h3E);
        expect_obs("R5 out", OBS_OUT, 8'h34);
        wr(REG_ODE, 8'h13);
        step(1);
        expect_obs("R5 od oe", OBS_OE, 8'h2E);
        expect_obs("R5 od out", OBS_OUT, 8'h24);

        // R6 pulls and slew
        wr(REG_PU, 8'h81);
        wr(REG_PD, 8'h42);
        wr(REG_SLEW, 8'h3C);
        step(1);
        expect_obs("R6 pu", OBS_PU, 8'h81);
        expect_obs("R6 pd", OBS_PD, 8'h42);
        expect_obs("R6 slew", OBS_SLEW, 8'h3C);
        expect_rd("R6 slew rd", REG_SLEW, 8'h3C);

        // R7 edge sensing setup
        wr(REG_ALT, 8'h00);
        wr(REG_DIR, 8'h00);
        wr(REG_ODE, 8'h00);
        wr(REG_SENSE, 8'h00);
        wr(REG_BOTH, 8'h04);
        wr(REG_EVT, 8'h01);
        wr(REG_MASK, 8'hFF);
        pad_in = 8'h00;
        step(5);
        wr(REG_RAW, 8'hFF);
        expect_rd("R8 cleared", REG_RAW, 8'h00);
        pad_in = 8'h07;
        step(5);
        expect_rd("R7 rise", REG_RAW, 8'h05);
        pad_in = 8'h00;
        step(5);
        expect_rd("R7 fall sticky", REG_RAW, 8'h07);
        expect_obs("R10 irq on", OBS_IRQ, 8'h01);

        // R8 write-one-to-clear
        wr(REG_RAW, 8'h01);
        expect_rd("R8 w1c", REG_RAW, 8'h06);
        wr(REG_RAW, 8'h00);
        expect_rd("R8 zero write", REG_RAW, 8'h06);

        // R10 mask
        wr(REG_MASK, 8'h01);
        expect_rd("R10 mis none", REG_MIS, 8'h00);
        expect_obs("R10 irq off", OBS_IRQ, 8'h00);
        wr(REG_MASK, 8'h04);
        expect_rd("R10 mis", REG_MIS, 8'h04);
        expect_obs("R10 irq", OBS_IRQ, 8'h01);

        // R9 level sensing on pin 3
        wr(REG_SENSE, 8'h08);
        wr(REG_EVT, 8'h09);
        pad_in = 8'h08;
        step(5);
        expect_rd("R9 high", REG_RAW, 8'h0E);
        wr(REG_RAW, 8'h08);
        expect_rd("R9 clear ignored", REG_RAW, 8'h0E);
        pad_in = 8'h00;
        step(5);
        expect_rd("R9 low", REG_RAW, 8'h06);

        // R11 lock
        wr(REG_LOCK, 8'hFF);
        expect_rd("R11 lock bits", REG_LOCK, 8'h03);
        wr(REG_DIR, 8'hFF);
        expect_rd("R11 dir", REG_DIR, 8'hFC);
        wr(REG_DEN, 8'h00);
        expect_rd("R11 den", REG_DEN, 8'h03);
        wr(REG_LOCK, 8'h00);
        expect_rd("R11 no unlock", REG_LOCK, 8'h03);
        wr(REG_DOUT, 8'hFF);
        expect_rd("R11 dout free", REG_DOUT, 8'hFF);

        step(3);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule